// File: doc/BRIEF.md
# RGB parallel display input receiver

This block accepts a synchronous parallel video stream on an 18-bit data bus. The stream is clocked by the dot clock, framed by a frame sync and a line sync, and qualified by a data-enable and a data-valid input. A 2-bit format setting selects how pixels arrive on the bus. The choices are one full 18-bit pixel per clock, one 16-bit pixel per clock, or a 6-bit bus that needs three clocks per pixel. In every case the block assembles a 6:6:6 pixel and emits it with a one-cycle write strobe, a row index and a column index. These outputs are meant to feed a display memory writer.

Alongside the pixel path, a frame sequencer follows the vertical position within each frame. After each frame sync it counts back-porch lines, then display lines, and then stays in the front porch until the next frame sync. The back-porch length, front-porch length and display-line code are programmable inputs. A registered error flag reports settings that break the porch rules or the line limit, and it also reports the reserved format code.

The dot clock is the block clock `clk` and runs without pause, including through the porches. All outputs are registered.

Top module: `rgb_rx_top`

## Requirements
- R1: With `fmt` = 00, each accepted clock yields one pixel equal to `pd[17:0]`. Red is bits 17..12, green is bits 11..6 and blue is bits 5..0.
- R2: With `fmt` = 01, each accepted clock yields one pixel. Red is `pd[17:13]` with its MSB copied into the LSB, green is `pd[11:6]`, and blue is `pd[5:1]` with its MSB copied into the LSB. Pins 12 and 0 have no effect.
- R3: With `fmt` = 10, three accepted clocks carry red, green and blue in that order on `pd[17:12]`, and the strobe fires only for the third. A rising edge of `hsync` or `vsync` discards a partial triplet.
- R4: With `fmt` = 11, no pixel strobe is issued.
- R5: A clock is accepted only when `de` and `dv` are both high, the phase is display, the format is valid, and no rising edge of `hsync` or `vsync` occurs in that clock. An accepted pixel appears on `px_we` one clock later.
- R6: `phase` encodes 0 as back porch, 1 as display and 2 as front porch. A rising edge of `vsync` enters back porch. The sequencer moves to display after `bp_lines` rising edges of `hsync`.
- R7: For code N on `dl_code`, the display period lasts min(8×(N+1), 240) rising edges of `hsync`, and then the front porch begins.
- R8: The front porch holds until the next rising edge of `vsync`. A `vsync` edge in any phase, including mid-display, restarts the back porch.
- R9: `px_col` counts strobes from 0 and restarts after every `hsync` or `vsync` edge. `px_row` is the display-line index, counted from 0 at the start of the display period.
- R10: One clock after the settings are sampled, `cfg_err` is high exactly when any of these holds: `fmt` = 11, a porch is below 2 or above 14, `bp_lines` + `fp_lines` > 16, or 8×(N+1) > 240.
- R11: During and right after reset, `px_we` and `cfg_err` are 0 and `phase` is 2 (front porch, waiting for a frame sync).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, free running |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Frame sync, rising edge significant |
| hsync | input | 1 | Line sync, rising edge significant |
| de | input | 1 | Data enable |
| dv | input | 1 | Data valid |
| pd | input | 18 | Parallel pixel data bus |
| fmt | input | 2 | Bus format select |
| bp_lines | input | 4 | Back-porch line count |
| fp_lines | input | 4 | Front-porch line count (checked only) |
| dl_code | input | 5 | Display-line code N |
| px_we | output | 1 | One-cycle pixel write strobe |
| px_data | output | 18 | Assembled 6:6:6 pixel |
| px_row | output | 8 | Display-line index of the pixel |
| px_col | output | 9 | Column index of the pixel |
| phase | output | 2 | Vertical phase |
| cfg_err | output | 1 | Illegal settings flag |

## Verification
The assertions assume the settings (`fmt`, porch counts, line code) stay constant while a frame is being received. They also assume the sync inputs are sampled exactly as driven, so a rising edge is one clock high after one clock low. The stimulus changes settings only at frame sync boundaries. It drives every input on the falling clock edge, so each edge the design sees is also seen by the reference model. It varies `de` and `dv` randomly and sends data during every porch line. It also cuts one frame short with an early `vsync` to exercise restart from the display phase.

// File: rtl/rgb_rx_pkg.sv
package rgb_rx_pkg;
  typedef enum logic [1:0] {
    PH_BACK  = 2'd0,
    PH_DISP  = 2'd1,
    PH_FRONT = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FMT_18  = 2'd0,
    FMT_16  = 2'd1,
    FMT_6   = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  localparam int PIX_W  = 18;
  localparam int CH_W   = 6;
  localparam int LANES  = 3;
endpackage

// File: rtl/rgb_rx_cfg.sv
module rgb_rx_cfg
  import rgb_rx_pkg::*;
#(
  parameter int PORCH_W       = 4,
  parameter int DCODE_W       = 5,
  parameter int LINE_W        = 8,
  parameter int PORCH_MIN     = 2,
  parameter int PORCH_MAX     = 14,
  parameter int PORCH_SUM_MAX = 16,
  parameter int LINE_STEP     = 8,
  parameter int MAX_LINES     = 240
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         fmt,
  input  logic [PORCH_W-1:0] bp,
  input  logic [PORCH_W-1:0] fp,
  input  logic [DCODE_W-1:0] dcode,
  output logic [LINE_W-1:0]  disp_lines,
  output logic               err
);
  localparam int RAW_W = DCODE_W + $clog2(LINE_STEP) + 2;
  localparam int SUM_W = PORCH_W + 1;
  localparam logic [PORCH_W-1:0] P_MIN   = PORCH_W'(PORCH_MIN);
  localparam logic [PORCH_W-1:0] P_MAX   = PORCH_W'(PORCH_MAX);
  localparam logic [SUM_W-1:0]   P_SUM   = SUM_W'(PORCH_SUM_MAX);
  localparam logic [RAW_W-1:0]   L_MAX   = RAW_W'(MAX_LINES);
  localparam logic [RAW_W-1:0]   L_STEP  = RAW_W'(LINE_STEP);

  logic [RAW_W-1:0] raw_lines;
  logic [SUM_W-1:0] porch_sum;
  logic             bad_bp, bad_fp, bad_sum, bad_lines, bad_fmt;

  always_comb begin
    raw_lines = (RAW_W'(dcode) + RAW_W'(1)) * L_STEP;
    porch_sum = SUM_W'(bp) + SUM_W'(fp);
    bad_bp    = (bp < P_MIN) || (bp > P_MAX);
    bad_fp    = (fp < P_MIN) || (fp > P_MAX);
    bad_sum   = porch_sum > P_SUM;
    bad_lines = raw_lines > L_MAX;
    bad_fmt   = fmt == FMT_BAD;
    disp_lines = bad_lines ? LINE_W'(L_MAX) : LINE_W'(raw_lines);
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad_bp | bad_fp | bad_sum | bad_lines | bad_fmt;
  end
endmodule

// File: rtl/rgb_rx_frame.sv
module rgb_rx_frame
  import rgb_rx_pkg::*;
#(
  parameter int PORCH_W = 4,
  parameter int LINE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vs_edge,
  input  logic               hs_edge,
  input  logic [PORCH_W-1:0] bp,
  input  logic [LINE_W-1:0]  disp_lines,
  output phase_e             phase_o,
  output logic [LINE_W-1:0]  line_o
);
  phase_e            phase_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_nxt;

  assign line_nxt = line_q + LINE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FRONT;
      line_q  <= '0;
    end else if (vs_edge) begin
      phase_q <= PH_BACK;
      line_q  <= '0;
    end else if (hs_edge) begin
      unique case (phase_q)
        PH_BACK: begin
          if (line_nxt >= LINE_W'(bp)) begin
            phase_q <= PH_DISP;
            line_q  <= '0;
          end else begin
            line_q <= line_nxt;
          end
        end
        PH_DISP: begin
          if (line_nxt >= disp_lines) begin
            phase_q <= PH_FRONT;
            line_q  <= '0;
          end else begin
            line_q <= line_nxt;
          end
        end
        default: line_q <= line_q;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign line_o  = line_q;
endmodule

// File: rtl/rgb_rx_pack.sv
module rgb_rx_pack
  import rgb_rx_pkg::*;
#(
  parameter int LINE_W = 8,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              line_break,
  input  logic [1:0]        fmt,
  input  logic [PIX_W-1:0]  pd,
  input  logic [LINE_W-1:0] row_in,
  output logic              we_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o
);
  localparam int LANE_W = $clog2(LANES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane_q;
  logic [CH_W-1:0]   red_q, grn_q;
  logic [COL_W-1:0]  col_q;
  logic [PIX_W-1:0]  pix_c;
  logic              fire;
  logic              narrow;

  assign narrow = fmt == FMT_6;

  always_comb begin
    pix_c = pd;
    fire  = 1'b0;
    unique case (fmt)
      FMT_18: begin
        pix_c = pd;
        fire  = accept;
      end
      FMT_16: begin
        pix_c = {pd[17:13], pd[17], pd[11:6], pd[5:1], pd[5]};
        fire  = accept;
      end
      FMT_6: begin
        pix_c = {red_q, grn_q, pd[PIX_W-1 -: CH_W]};
        fire  = accept && (lane_q == LAST_LANE);
      end
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q <= '0;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (line_break) begin
      lane_q <= '0;
    end else if (accept && narrow) begin
      if (lane_q == '0)        red_q <= pd[PIX_W-1 -: CH_W];
      if (lane_q == LANE_W'(1)) grn_q <= pd[PIX_W-1 -: CH_W];
      lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + LANE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      we_o  <= 1'b0;
      pix_o <= '0;
      row_o <= '0;
      col_o <= '0;
    end else begin
      we_o <= fire;
      if (fire) begin
        pix_o <= pix_c;
        row_o <= row_in;
        col_o <= col_q;
      end
      if (line_break)  col_q <= '0;
      else if (fire)   col_q <= col_q + COL_W'(1);
    end
  end
endmodule

// File: rtl/rgb_rx_top.sv
module rgb_rx_top
  import rgb_rx_pkg::*;
#(
  parameter int PORCH_W = 4,
  parameter int DCODE_W = 5,
  parameter int LINE_W  = 8,
  parameter int COL_W   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vsync,
  input  logic               hsync,
  input  logic               de,
  input  logic               dv,
  input  logic [17:0]        pd,
  input  logic [1:0]         fmt,
  input  logic [PORCH_W-1:0] bp_lines,
  input  logic [PORCH_W-1:0] fp_lines,
  input  logic [DCODE_W-1:0] dl_code,
  output logic               px_we,
  output logic [17:0]        px_data,
  output logic [LINE_W-1:0]  px_row,
  output logic [COL_W-1:0]   px_col,
  output logic [1:0]         phase,
  output logic               cfg_err
);
  logic              vs_q, hs_q;
  logic              vs_edge, hs_edge;
  logic              accept;
  logic [LINE_W-1:0] disp_lines;
  logic [LINE_W-1:0] line_idx;
  phase_e            ph;

  always_ff @(posedge clk) begin
    vs_q <= vsync;
    hs_q <= hsync;
  end

  assign vs_edge = vsync & ~vs_q;
  assign hs_edge = hsync & ~hs_q;
  assign accept  = de & dv & (ph == PH_DISP) & (fmt != FMT_BAD) & ~vs_edge & ~hs_edge;

  rgb_rx_cfg #(.PORCH_W(PORCH_W), .DCODE_W(DCODE_W), .LINE_W(LINE_W)) u_cfg (
    .clk(clk), .rst(rst), .fmt(fmt), .bp(bp_lines), .fp(fp_lines),
    .dcode(dl_code), .disp_lines(disp_lines), .err(cfg_err)
  );

  rgb_rx_frame #(.PORCH_W(PORCH_W), .LINE_W(LINE_W)) u_frame (
    .clk(clk), .rst(rst), .vs_edge(vs_edge), .hs_edge(hs_edge),
    .bp(bp_lines), .disp_lines(disp_lines), .phase_o(ph), .line_o(line_idx)
  );

  rgb_rx_pack #(.LINE_W(LINE_W), .COL_W(COL_W)) u_pack (
    .clk(clk), .rst(rst), .accept(accept), .line_break(vs_edge | hs_edge),
    .fmt(fmt), .pd(pd), .row_in(line_idx), .we_o(px_we), .pix_o(px_data),
    .row_o(px_row), .col_o(px_col)
  );

  assign phase = ph;
endmodule

// File: rtl/rgb_rx_chk.sv
module rgb_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       vsync,
  input logic [1:0] fmt,
  input logic       px_we,
  input logic [1:0] phase,
  input logic       cfg_err
);
  AST_WE_IN_DISPLAY: assert property (@(posedge clk) disable iff (rst)
    px_we |-> $past(phase) == 2'd1); // R5
  AST_NO_WE_BAD_FMT: assert property (@(posedge clk) disable iff (rst)
    px_we |-> $past(fmt) != 2'd3); // R4
  AST_BAD_FMT_FLAG: assert property (@(posedge clk) disable iff (rst)
    fmt == 2'd3 |=> cfg_err); // R10
  AST_VSYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |=> phase == 2'd0); // R8
  AST_FRONT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !$rose(vsync)) |=> phase == 2'd2); // R8
  AST_TRIPLET_GAP: assert property (@(posedge clk) disable iff (rst)
    (px_we && $past(fmt) == 2'd2 && fmt == 2'd2) |=> !px_we); // R3
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R6
endmodule

bind rgb_rx_top rgb_rx_chk u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .fmt(fmt), .px_we(px_we),
  .phase(phase), .cfg_err(cfg_err)
);

// File: tb/rgb_rx_top_tb.sv
module rgb_rx_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vsync = 1'b0, hsync = 1'b0, de = 1'b0, dv = 1'b0;
  logic [17:0] pd = '0;
  logic [1:0]  fmt = 2'd0;
  logic [3:0]  bp_lines = 4'd3, fp_lines = 4'd4;
  logic [4:0]  dl_code = 5'd0;
  logic        px_we;
  logic [17:0] px_data;
  logic [7:0]  px_row;
  logic [8:0]  px_col;
  logic [1:0]  phase;
  logic        cfg_err;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  rgb_rx_top u_dut (
    .clk(clk), .rst(rst), .vsync(vsync), .hsync(hsync), .de(de), .dv(dv),
    .pd(pd), .fmt(fmt), .bp_lines(bp_lines), .fp_lines(fp_lines),
    .dl_code(dl_code), .px_we(px_we), .px_data(px_data), .px_row(px_row),
    .px_col(px_col), .phase(phase), .cfg_err(cfg_err)
  );

  // Behavioural reference model, updated on every rising edge
  int          m_ph = 2, m_line = 0, m_col = 0;
  bit          m_pvs = 0, m_phs = 0;
  logic [5:0]  m_q[$];
  bit          e_we = 0, e_err = 0;
  int          e_ph = 2, e_row = 0, e_col = 0;
  logic [17:0] e_data = '0;
  int          e_fmt = 0;

  function automatic int lines_for(int n);
    return (8 * (n + 1) > 240) ? 240 : 8 * (n + 1);
  endfunction

  always @(posedge clk) begin
    bit vse, hse, acc;
    vse = vsync && !m_pvs;
    hse = hsync && !m_phs;
    m_pvs = vsync;
    m_phs = hsync;
    if (rst) begin
      m_ph = 2; m_line = 0; m_col = 0; m_q.delete();
      e_we = 0; e_err = 0; e_ph = 2;
    end else begin
      e_err = (fmt == 2'd3) || bp_lines < 2 || bp_lines > 14 || fp_lines < 2 ||
              fp_lines > 14 || (int'(bp_lines) + int'(fp_lines) > 16) ||
              (8 * (int'(dl_code) + 1) > 240);
      acc = de && dv && m_ph == 1 && fmt != 2'd3 && !vse && !hse;
      e_we = 0;
      e_fmt = fmt;
      if (acc) begin
        if (fmt == 2'd0) begin
          e_we = 1; e_data = pd;
        end else if (fmt == 2'd1) begin
          e_we = 1;
          e_data = {pd[17:13], pd[17], pd[11:6], pd[5:1], pd[5]};
        end else begin
          m_q.push_back(pd[17:12]);
          if (m_q.size() == 3) begin
            e_we = 1; e_data = {m_q[0], m_q[1], m_q[2]};
            m_q.delete();
          end
        end
        if (e_we) begin
          e_row = m_line; e_col = m_col; m_col++;
        end
      end
      if (vse || hse) begin
        m_col = 0; m_q.delete();
      end
      if (vse) begin
        m_ph = 0; m_line = 0;
      end else if (hse) begin
        if (m_ph == 0) begin
          if (m_line + 1 >= int'(bp_lines)) begin m_ph = 1; m_line = 0; end
          else m_line++;
        end else if (m_ph == 1) begin
          if (m_line + 1 >= lines_for(int'(dl_code))) begin m_ph = 2; m_line = 0; end
          else m_line++;
        end
      end
      e_ph = m_ph;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done && !rst) begin
      chk("R6 phase", int'(phase), e_ph);
      chk("R10 cfg_err", int'(cfg_err), int'(e_err));
      chk("R5 px_we", int'(px_we), int'(e_we));
      if (e_we && px_we) begin
        if (e_fmt == 0)      chk("R1 px_data", int'(px_data), int'(e_data));
        else if (e_fmt == 1) chk("R2 px_data", int'(px_data), int'(e_data));
        else                 chk("R3 px_data", int'(px_data), int'(e_data));
        chk("R9 px_row", int'(px_row), e_row);
        chk("R9 px_col", int'(px_col), e_col);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic line(int npix, bit gaps);
    hsync = 1'b1; de = 1'b1; dv = 1'b1; pd = 18'($urandom);
    step();
    hsync = 1'b0;
    for (int i = 0; i < npix; i++) begin
      de = gaps ? ($urandom % 5 != 0) : 1'b1;
      dv = gaps ? ($urandom % 4 != 0) : 1'b1;
      pd = 18'($urandom);
      step();
    end
    de = 1'b0; dv = 1'b0;
    step();
  endtask

  task automatic frame(int nlines, int npix, bit gaps, int idle);
    vsync = 1'b1;
    step();
    vsync = 1'b0;
    for (int l = 0; l < nlines; l++) line(npix, gaps);
    for (int i = 0; i < idle; i++) step();  // R8 front porch idles until vsync
  endtask

  task automatic settings(int f, int b, int p, int n);
    fmt = 2'(f); bp_lines = 4'(b); fp_lines = 4'(p); dl_code = 5'(n);
    step(); step();
  endtask

  initial begin
    repeat (4) step();
    // R11 reset state
    chk("R11 reset px_we", int'(px_we), 0);
    chk("R11 reset phase", int'(phase), 2);
    chk("R11 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    step();
    chk("R11 after reset phase", int'(phase), 2);
    // 18-bit format, 8 display lines, gaps in enable/valid
    settings(0, 3, 4, 0);
    frame(3 + 8 + 6, 6, 1, 30);
    frame(3 + 8 + 4, 5, 0, 10);
    // 16-bit format
    settings(1, 2, 14, 1);
    frame(2 + 16 + 5, 7, 1, 12);
    // 6-bit format with partial triplets at line ends (R3)
    settings(2, 4, 2, 0);
    frame(4 + 8 + 3, 8, 0, 8);
    frame(4 + 8 + 3, 10, 1, 8);
    // Reserved format: nothing written (R4)
    settings(3, 3, 4, 0);
    frame(3 + 8 + 2, 6, 0, 8);
    // R10 settings error corners
    settings(0, 1, 4, 0);
    settings(0, 3, 15, 0);
    settings(0, 8, 9, 0);
    settings(0, 2, 14, 0);
    settings(0, 3, 4, 30);
    // R7 display length limit: code 29 gives 240 lines, code 31 caps at 240
    settings(0, 2, 2, 29);
    frame(2 + 240 + 3, 2, 0, 6);
    settings(0, 2, 2, 31);
    frame(2 + 240 + 3, 2, 0, 6);
    // R8 vsync during display restarts back porch
    settings(0, 3, 4, 1);
    frame(3 + 5, 4, 0, 0);
    frame(3 + 16 + 3, 4, 1, 5);
    repeat (4) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule